// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block lets a host reach registers inside on-chip units over a sideband message bus. The host sees a small register window: a control word, an extended-offset word, a data word and a status word. Writing the control word with its enable nibble set fires exactly one sideband transaction. The port, the opcode and the low address byte come from that same control word. The upper address bits come from the extended-offset word, which the host loads beforehand. Bit 0 of the opcode picks the direction. A write transaction sends the data word out. A read transaction loads the reply into the data word.

The sideband request leaves through a valid/ready channel. Once `sb_req_valid` is raised it stays high, and port, opcode, address and write data stay unchanged, until a cycle in which `sb_req_ready` is high. The sideband responder may hold `sb_req_ready` low for any number of cycles. The bridge then waits for a one-cycle response strobe. It raises `sb_rsp_ready` only while it waits, and it never refuses a strobe in that state.

One port number, the graphics unit, is refused. A control write aimed at it raises a sticky error flag, and no request appears on the bus. A read-modify-write is made of two transactions. The host first runs a read, merges the new bits under its mask, then runs a write.

Top module: `sb_mailbox_bridge`

## Requirements
- R1: Register select 0 is the control word. Bits 31:24 hold the opcode, bits 23:16 the target port and bits 15:8 the low address byte. A launched request carries these fields on `sb_req_opcode` and `sb_req_port`.
- R2: Register select 1 is the extended offset. A write stores bits 31:8, and a readback returns those bits with bits 7:0 as zero. The request address is {extended bits 31:8, control bits 15:8}.
- R3: A control write launches a transaction only when bits 7:4 of the written value are all ones. Any other value only updates the stored control word, and no request is raised.
- R4: When opcode bit 0 is 1 (write), `sb_req_wdata` equals the data word (select 2), and the data word is unchanged after completion.
- R5: When opcode bit 0 is 0 (read), the data word takes `sb_rsp_data` at the edge where `sb_rsp_valid` is high. Busy is clear from that same edge on.
- R6: Status (select 3) bit 0 is busy. It is 1 from the edge that accepts a launching control write until the response edge. `sb_req_valid` rises at that same edge.
- R7: While busy, host writes to the control, extended-offset and data words are ignored.
- R8: The extended offset keeps its value after a transaction completes.
- R9: A launching control write whose port equals GFX_PORT (default 8'h06) raises no request and sets status bit 1. That bit stays set until the host writes status with bit 1 set.
- R10: While `sb_req_valid` is high and `sb_req_ready` is low, the request stays valid with unchanged fields.
- R11: A read followed by a write to the same address moves the host-merged value (old bits where the mask is 0, new bits where it is 1) onto `sb_req_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Selected register value (combinational) |
| sb_req_valid | output | 1 | Sideband request valid |
| sb_req_ready | input | 1 | Sideband request accepted |
| sb_req_port | output | 8 | Target port |
| sb_req_opcode | output | 8 | Opcode |
| sb_req_addr | output | 32 | Target address |
| sb_req_wdata | output | 32 | Write payload |
| sb_rsp_valid | input | 1 | Response strobe |
| sb_rsp_ready | output | 1 | Bridge awaiting a response |
| sb_rsp_data | input | 32 | Read reply |

## Verification
The assertions assume a well-behaved responder. It sends a response strobe only while `sb_rsp_ready` is high. It keeps `sb_req_ready` meaningful only while a request is pending. It holds the host strobe low during reset. The bench plays that responder: it pulses `sb_rsp_valid` for exactly one cycle after each accepted request, and it stalls `sb_req_ready` only around a pending request. Inputs change only on falling edges. The bench waits for each response before it starts the next transaction, so it never relies on behaviour outside that contract.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SBM_DATA_W = 32;
  localparam int SBM_SEL_W  = 2;

  localparam logic [SBM_SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SBM_SEL_W-1:0] SEL_EXT  = 2'd1;
  localparam logic [SBM_SEL_W-1:0] SEL_DATA = 2'd2;
  localparam logic [SBM_SEL_W-1:0] SEL_STAT = 2'd3;

  localparam logic [3:0] ENABLE_NIBBLE = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sbm_state_e;
endpackage

// File: rtl/sbm_launch.sv
module sbm_launch #(
  parameter logic [7:0] GFX_PORT = 8'h06
) (
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_port,
  input  logic [3:0] wr_enable,
  input  logic       busy,
  output logic       launch,
  output logic       refuse
);
  import sbm_pkg::*;

  logic fire;

  always_comb begin
    fire   = wr_en && !busy && (wr_sel == SEL_CTRL) && (wr_enable == ENABLE_NIBBLE);
    refuse = fire && (wr_port == GFX_PORT);
    launch = fire && (wr_port != GFX_PORT);
  end
endmodule

// File: rtl/sbm_regfile.sv
module sbm_regfile #(
  parameter int DATA_W = sbm_pkg::SBM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  input  logic              capture,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-9:0] ext_q,
  output logic [DATA_W-1:0] data_q
);
  import sbm_pkg::*;

  logic host_ok;
  assign host_ok = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ext_q  <= '0;
      data_q <= '0;
    end else begin
      if (host_ok && wr_sel == SEL_CTRL) ctrl_q <= wr_data;
      if (host_ok && wr_sel == SEL_EXT)  ext_q  <= wr_data[DATA_W-1:8];
      if (capture)                       data_q <= rsp_data;
      else if (host_ok && wr_sel == SEL_DATA) data_q <= wr_data;
    end
  end

  // R7: a locked window rejects host writes to every stored word
  a_r7_ext_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && wr_sel == SEL_EXT) |=> $stable(ext_q));
  a_r7_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && wr_sel == SEL_CTRL) |=> $stable(ctrl_q));
  a_r7_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !capture && wr_en && wr_sel == SEL_DATA) |=> $stable(data_q));
endmodule

// File: rtl/sbm_txn_fsm.sv
module sbm_txn_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic refuse,
  input  logic err_clr,
  input  logic is_write,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic rsp_ready,
  output logic busy,
  output logic err,
  output logic capture
);
  import sbm_pkg::*;

  sbm_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (launch)    state_nx = ST_REQ;
      ST_REQ:  if (req_ready) state_nx = ST_WAIT;
      ST_WAIT: if (rsp_valid) state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= state_nx;
      if (refuse)       err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign req_valid = (state == ST_REQ);
  assign rsp_ready = (state == ST_WAIT);
  assign busy      = (state != ST_IDLE);
  assign capture   = rsp_ready && rsp_valid && !is_write;

  // R6: busy holds while the response is outstanding
  a_r6_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !rsp_valid) |=> busy);
  // R5: response strobe ends the transaction at once
  a_r5_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_valid) |=> !busy);
  // R10: request stays offered under back-pressure
  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
  // R9: the error flag is sticky without a clear
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
endmodule

// File: rtl/sb_mailbox_bridge.sv
module sb_mailbox_bridge #(
  parameter int         DATA_W   = 32,
  parameter logic [7:0] GFX_PORT = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sb_req_valid,
  input  logic              sb_req_ready,
  output logic [7:0]        sb_req_port,
  output logic [7:0]        sb_req_opcode,
  output logic [DATA_W-1:0] sb_req_addr,
  output logic [DATA_W-1:0] sb_req_wdata,
  input  logic              sb_rsp_valid,
  output logic              sb_rsp_ready,
  input  logic [DATA_W-1:0] sb_rsp_data
);
  import sbm_pkg::*;

  localparam int OP_LSB   = DATA_W - 8;
  localparam int PORT_LSB = DATA_W - 16;
  localparam int LO_LSB   = 8;
  localparam int EN_LSB   = 4;

  logic [DATA_W-1:0] ctrl_q, data_q;
  logic [DATA_W-9:0] ext_q;
  logic launch, refuse, busy, err, capture, err_clr;

  assign err_clr = reg_wr && reg_addr == SEL_STAT && reg_wdata[1];

  sbm_launch #(.GFX_PORT(GFX_PORT)) u_launch (
    .wr_en     (reg_wr),
    .wr_sel    (reg_addr),
    .wr_port   (reg_wdata[PORT_LSB +: 8]),
    .wr_enable (reg_wdata[EN_LSB +: 4]),
    .busy      (busy),
    .launch    (launch),
    .refuse    (refuse)
  );

  sbm_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_sel   (reg_addr),
    .wr_data  (reg_wdata),
    .lock     (busy),
    .capture  (capture),
    .rsp_data (sb_rsp_data),
    .ctrl_q   (ctrl_q),
    .ext_q    (ext_q),
    .data_q   (data_q)
  );

  sbm_txn_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .refuse    (refuse),
    .err_clr   (err_clr),
    .is_write  (ctrl_q[OP_LSB]),
    .req_ready (sb_req_ready),
    .rsp_valid (sb_rsp_valid),
    .req_valid (sb_req_valid),
    .rsp_ready (sb_rsp_ready),
    .busy      (busy),
    .err       (err),
    .capture   (capture)
  );

  assign sb_req_opcode = ctrl_q[OP_LSB +: 8];
  assign sb_req_port   = ctrl_q[PORT_LSB +: 8];
  assign sb_req_addr   = {ext_q, ctrl_q[LO_LSB +: 8]};
  assign sb_req_wdata  = data_q;

  always_comb begin
    unique case (reg_addr)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_EXT:  reg_rdata = {ext_q, 8'h00};
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = {{(DATA_W-2){1'b0}}, err, busy};
    endcase
  end

  // R9: the refused port never reaches the bus
  a_r9_no_gfx: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid |-> sb_req_port != GFX_PORT);
  // R10: fields are frozen while the request waits
  a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req_valid && !sb_req_ready) |=> ($stable(sb_req_addr) && $stable(sb_req_wdata)
                                          && $stable(sb_req_opcode)));
  // R3: a request only rises after an enabled control write
  a_r3_launch_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req_valid) |-> $past(reg_wr && reg_addr == SEL_CTRL
                                  && reg_wdata[EN_LSB +: 4] == ENABLE_NIBBLE));
endmodule

// File: tb/sb_mailbox_bridge_tb.sv
module sb_mailbox_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sb_req_valid, sb_rsp_ready;
  logic        sb_req_ready = 1'b1;
  logic [7:0]  sb_req_port, sb_req_opcode;
  logic [31:0] sb_req_addr, sb_req_wdata;
  logic        sb_rsp_valid = 1'b0;
  logic [31:0] sb_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sb_mailbox_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
    .sb_req_port(sb_req_port), .sb_req_opcode(sb_req_opcode),
    .sb_req_addr(sb_req_addr), .sb_req_wdata(sb_req_wdata),
    .sb_rsp_valid(sb_rsp_valid), .sb_rsp_ready(sb_rsp_ready),
    .sb_rsp_data(sb_rsp_data)
  );

  // {port, opcode, ext[31:8], lo, wdata, rsp}
  localparam logic [111:0] VEC [4] = '{
    {8'h03, 8'h11, 24'h000000, 8'h34, 32'hDEADBEEF, 32'h0},
    {8'h04, 8'h10, 24'hABCDEF, 8'h7F, 32'h0,        32'h13579BDF},
    {8'h05, 8'h07, 24'h123456, 8'hFF, 32'hFFFF0000, 32'h0},
    {8'h02, 8'h06, 24'hFFFFFF, 8'h00, 32'h0,        32'hCAFEF00D}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic respond(input logic [31:0] d);
    sb_rsp_valid = 1'b1; sb_rsp_data = d;
    @(negedge clk);
    sb_rsp_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d expected below 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, old, merged;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_rd(2'd3, v); chk("R6 reset status", v, 32'h0);
    host_rd(2'd0, v); chk("R1 reset control", v, 32'h0);
    chk("R6 reset req_valid", {31'b0, sb_req_valid}, 32'h0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] p, op, lo; logic [23:0] ex; logic [31:0] wd, rs, exp_d;
      {p, op, ex, lo, wd, rs} = VEC[i];
      host_wr(2'd2, wd);
      host_wr(2'd1, {ex, 8'h00});
      host_rd(2'd1, v); chk("R2 ext readback", v, {ex, 8'h00});
      host_wr(2'd0, {op, p, lo, 8'hF0});
      chk("R6 req_valid after launch", {31'b0, sb_req_valid}, 32'h1);
      chk("R1 opcode/port", {16'h0, sb_req_opcode, sb_req_port}, {16'h0, op, p});
      chk("R2 address", sb_req_addr, {ex, lo});
      if (op[0]) chk("R4 write payload", sb_req_wdata, wd);
      host_rd(2'd3, v); chk("R6 busy set", v & 32'h1, 32'h1);
      @(negedge clk);
      chk("R6 waiting rsp", {31'b0, sb_rsp_ready}, 32'h1);
      respond(rs);
      host_rd(2'd3, v); chk("R5 busy clear", v & 32'h1, 32'h0);
      exp_d = op[0] ? wd : rs;
      host_rd(2'd2, v); chk(op[0] ? "R4 data kept" : "R5 data captured", v, exp_d);
      host_rd(2'd1, v); chk("R8 ext kept", v, {ex, 8'h00});
    end

    // R3: enable nibble not all ones
    host_wr(2'd0, 32'h11034570);
    chk("R3 no launch", {31'b0, sb_req_valid}, 32'h0);
    host_rd(2'd3, v); chk("R3 not busy", v, 32'h0);
    host_rd(2'd0, v); chk("R3 stored", v, 32'h11034570);

    // R10: back-pressure, then R7 writes while busy
    host_wr(2'd2, 32'h0BADC0DE);
    host_wr(2'd1, 32'h55AA5500);
    sb_req_ready = 1'b0;
    host_wr(2'd0, 32'h110322F0);
    repeat (3) @(negedge clk);
    chk("R10 held valid", {31'b0, sb_req_valid}, 32'h1);
    chk("R10 held addr", sb_req_addr, 32'h55AA5522);
    host_wr(2'd2, 32'h11111111);
    host_wr(2'd1, 32'h22222200);
    host_wr(2'd0, 32'h10099FF0);
    chk("R7 addr unchanged", sb_req_addr, 32'h55AA5522);
    sb_req_ready = 1'b1;
    @(negedge clk);
    respond(32'h0);
    host_rd(2'd2, v); chk("R7 data ignored", v, 32'h0BADC0DE);
    host_rd(2'd1, v); chk("R7 ext ignored", v, 32'h55AA5500);
    host_rd(2'd0, v); chk("R7 ctrl ignored", v, 32'h110322F0);

    // R9: refused port
    host_wr(2'd0, 32'h1106AAF0);
    chk("R9 no request", {31'b0, sb_req_valid}, 32'h0);
    host_rd(2'd3, v); chk("R9 error set", v, 32'h2);
    @(negedge clk);
    host_rd(2'd3, v); chk("R9 error sticky", v, 32'h2);
    host_wr(2'd3, 32'h2);
    host_rd(2'd3, v); chk("R9 error cleared", v, 32'h0);

    // R11: read-modify-write
    host_wr(2'd1, 32'h00C0DE00);
    host_wr(2'd0, 32'h100310F0);
    @(negedge clk);
    respond(32'hAAAA5555);
    host_rd(2'd2, old);
    merged = (old & ~32'h0000FFFF) | (32'h12341234 & 32'h0000FFFF);
    host_wr(2'd2, merged);
    host_wr(2'd0, 32'h110310F0);
    chk("R11 merged payload", sb_req_wdata, 32'hAAAA1234);
    chk("R11 address", sb_req_addr, 32'h00C0DE10);
    @(negedge clk);
    respond(32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule